// File: doc/BRIEF.md
# Linear Page Table Translation Unit

This block translates every processor access (load, store or instruction fetch) from a virtual address to a physical one. Before the real access, it walks a one-level page table that sits in the same physical memory. The virtual address splits into a page number and an in-page offset. The page number indexes a linear array of two-byte entries, and the array starts at a base address supplied on an input. Each entry holds a flag byte, and the byte after it holds the frame number.

After it reads the entry, the unit checks three things: that the page is mapped, that it is resident, and that it may be used for this request type and privilege. A failing request is answered with a trap code and touches nothing else. A passing request has its accessed and dirty flags brought up to date in memory when they change. The unit then performs the access at the frame number joined to the unchanged offset.

The processor side uses a valid/ready handshake and has one request in flight at a time. The memory side is a single byte-wide port. Read data appears on it in the cycle after the request, and writes take effect at the request's clock edge.

Top module: `pt_xlate_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle, which is also the state after reset. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After each one-cycle `rsp_valid` pulse the unit is ready again in the next cycle.
- R2: Each request begins with two memory reads. The first reads the flag byte at `pt_base + 2*VPN`, and the second reads the frame byte at `pt_base + 2*VPN + 1`. The VPN is `req_vaddr[5:4]`. Nothing else is issued before both reads.
- R3: The data access goes to the physical address `{frame[2:0], req_vaddr[3:0]}`. For example, virtual address 21 with page 1 mapped to frame 7 goes to 0x75.
- R4: A flag byte with bit 7 (valid) clear gives trap code 01.
- R5: A valid entry with bit 6 (present) clear gives trap code 10.
- R6: A protection failure gives trap code 11. `req_kind` 00 (load) needs flag bit 5, 01 (store) needs bit 4, and 10 or 11 (fetch) needs bit 3. A request with `req_user`=1 also needs bit 2.
- R7: The checks take priority in this order: invalid, then not present, then protection.
- R8: A faulting request makes no memory access after the two table reads. It answers with `rsp_valid` and the trap code. `rsp_trap` is 00 whenever `rsp_valid` is low.
- R9: A successful access sets flag bit 1 (accessed), and a successful store also sets bit 0 (dirty). The flag byte is written back to memory once, before the data access, and only if its value changes.
- R10: A successful load or fetch returns the byte at the physical address on `rsp_rdata`. A successful store writes `req_wdata` there and returns 0. Both answer with trap 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_base | input | 7 | Physical address of the first table entry |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_vaddr | input | 6 | Virtual address |
| req_kind | input | 2 | 00 load, 01 store, 10/11 fetch |
| req_user | input | 1 | 1 for a user-mode request |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_trap | output | 2 | 00 none, 01 invalid, 10 not present, 11 protection |
| rsp_rdata | output | 8 | Load or fetch data |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 7 | Physical byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |

## Verification
The bound checker enforces the following on every cycle:
- the handshake and return-to-ready rule;
- silence on the memory port around a fault answer;
- a zero trap code outside responses;
- the data-access offset matching the accepted virtual address.

Only the directed scenarios can show the rest:
- the table-entry addresses under two different bases;
- each trap code and their priority;
- the flag byte in memory after loads and stores;
- that a second access to the same page adds no writeback;
- the data returned or stored at the translated address.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_PTE,
        ST_CHECK,
        ST_WRITEBACK_PTE,
        ST_DATA_ACCESS,
        ST_RESPOND,
        ST_FAULT
    } xl_state_e;

    localparam logic [1:0] KIND_LOAD  = 2'b00;
    localparam logic [1:0] KIND_STORE = 2'b01;

    localparam logic [1:0] TRAP_NONE    = 2'b00;
    localparam logic [1:0] TRAP_INVALID = 2'b01;
    localparam logic [1:0] TRAP_ABSENT  = 2'b10;
    localparam logic [1:0] TRAP_PROT    = 2'b11;

    // flag byte bit positions
    localparam int FB_VALID   = 7;
    localparam int FB_PRESENT = 6;
    localparam int FB_RD      = 5;
    localparam int FB_WR      = 4;
    localparam int FB_EX      = 3;
    localparam int FB_USER    = 2;
    localparam int FB_ACC     = 1;
    localparam int FB_DIRTY   = 0;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int VA_W       = 6,
    parameter int PAGE_OFS_W = 4,
    parameter int PA_W       = 7
) (
    input  logic [PA_W-1:0]            base,
    input  logic [VA_W-1:0]            vaddr,
    input  logic [PA_W-PAGE_OFS_W-1:0] pfn,
    output logic [PA_W-1:0]            ent_addr,
    output logic [PA_W-1:0]            phys_addr
);
    localparam int VPN_W = VA_W - PAGE_OFS_W;

    logic [VPN_W-1:0] vpn;

    always_comb begin
        vpn       = vaddr[VA_W-1:PAGE_OFS_W];
        // two bytes per entry: index scaled by two
        ent_addr  = base + {{(PA_W-VPN_W-1){1'b0}}, vpn, 1'b0};
        phys_addr = {pfn, vaddr[PAGE_OFS_W-1:0]};
    end
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_xlate_pkg::*;
(
    input  logic [7:0] flags,
    input  logic [1:0] kind,
    input  logic       user,
    output logic [1:0] trap,
    output logic [7:0] flags_new,
    output logic       need_wb
);
    logic allowed;

    always_comb begin
        case (kind)
            KIND_LOAD:  allowed = flags[FB_RD];
            KIND_STORE: allowed = flags[FB_WR];
            default:    allowed = flags[FB_EX];
        endcase
        if (user && !flags[FB_USER]) allowed = 1'b0;

        if (!flags[FB_VALID])        trap = TRAP_INVALID;
        else if (!flags[FB_PRESENT]) trap = TRAP_ABSENT;
        else if (!allowed)           trap = TRAP_PROT;
        else                         trap = TRAP_NONE;

        flags_new            = flags;
        flags_new[FB_ACC]    = 1'b1;
        if (kind == KIND_STORE) flags_new[FB_DIRTY] = 1'b1;
        need_wb = (flags_new != flags);
    end
endmodule

// File: rtl/pt_xlate_unit.sv
module pt_xlate_unit
    import pt_xlate_pkg::*;
#(
    parameter int VA_W       = 6,
    parameter int PAGE_OFS_W = 4,
    parameter int PA_W       = 7,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   pt_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_trap,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int PFN_W = PA_W - PAGE_OFS_W;

    typedef struct packed {
        xl_state_e          st;
        logic [1:0]         ph;
        logic [VA_W-1:0]    va;
        logic [1:0]         kind;
        logic               user;
        logic [DATA_W-1:0]  wd;
        logic [7:0]         flags;
        logic [PFN_W-1:0]   pfn;
        logic [1:0]         trap;
        logic [DATA_W-1:0]  rd;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: ST_IDLE, default: '0};

    ctl_t q, d;

    logic [PA_W-1:0] ent_addr, phys_addr;
    logic [1:0]      trap_c;
    logic [7:0]      flags_new;
    logic            need_wb;

    pt_addr_gen #(.VA_W(VA_W), .PAGE_OFS_W(PAGE_OFS_W), .PA_W(PA_W)) u_addr (
        .base(pt_base), .vaddr(q.va), .pfn(q.pfn),
        .ent_addr(ent_addr), .phys_addr(phys_addr)
    );

    pt_perm_check u_perm (
        .flags(q.flags), .kind(q.kind), .user(q.user),
        .trap(trap_c), .flags_new(flags_new), .need_wb(need_wb)
    );

    always_comb begin
        d         = q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.va   = req_vaddr;
                    d.kind = req_kind;
                    d.user = req_user;
                    d.wd   = req_wdata;
                    d.trap = TRAP_NONE;
                    d.rd   = '0;
                    d.ph   = 2'd0;
                    d.st   = ST_FETCH_PTE;
                end
            end
            ST_FETCH_PTE: begin
                // beat 0: read flags; beat 1: read frame, take flags; beat 2: take frame
                mem_req  = (q.ph != 2'd2);
                mem_addr = (q.ph == 2'd0) ? ent_addr : ent_addr + PA_W'(1);
                d.ph     = q.ph + 2'd1;
                if (q.ph == 2'd1) d.flags = mem_rdata[7:0];
                if (q.ph == 2'd2) begin
                    d.pfn = mem_rdata[PFN_W-1:0];
                    d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                d.trap = trap_c;
                d.ph   = 2'd0;
                if (trap_c != TRAP_NONE) d.st = ST_FAULT;
                else if (need_wb)        d.st = ST_WRITEBACK_PTE;
                else                     d.st = ST_DATA_ACCESS;
            end
            ST_WRITEBACK_PTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ent_addr;
                mem_wdata = DATA_W'(flags_new);
                d.flags   = flags_new;
                d.st      = ST_DATA_ACCESS;
            end
            ST_DATA_ACCESS: begin
                if (q.ph == 2'd0) begin
                    mem_req   = 1'b1;
                    mem_we    = (q.kind == KIND_STORE);
                    mem_addr  = phys_addr;
                    mem_wdata = q.wd;
                    d.ph      = 2'd1;
                end else begin
                    d.rd = (q.kind == KIND_STORE) ? '0 : mem_rdata;
                    d.st = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                rsp_valid = 1'b1;
                d.st      = ST_IDLE;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        rsp_trap  = rsp_valid ? q.trap : TRAP_NONE;
        rsp_rdata = rsp_valid ? q.rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RESET;
        else        q <= d;
    end
endmodule

// File: rtl/pt_xlate_unit_chk.sv
module pt_xlate_unit_chk
    import pt_xlate_pkg::*;
#(
    parameter int VA_W       = 6,
    parameter int PAGE_OFS_W = 4,
    parameter int PA_W       = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [1:0]      rsp_trap,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input xl_state_e       st,
    input logic [1:0]      ph
);
    logic [VA_W-1:0] va_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      va_seen <= '0;
        else if (req_valid && req_ready) va_seen <= req_vaddr;
    end

    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    p_rsp_then_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    p_phys_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA_ACCESS && ph == 2'd0) |->
            (mem_req && mem_addr[PAGE_OFS_W-1:0] == va_seen[PAGE_OFS_W-1:0]));

    p_fault_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap != 2'b00) |-> (!mem_req && !$past(mem_req)));

    p_trap_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_trap == 2'b00));
endmodule

bind pt_xlate_unit pt_xlate_unit_chk #(
    .VA_W(VA_W), .PAGE_OFS_W(PAGE_OFS_W), .PA_W(PA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_trap(rsp_trap),
    .mem_req(mem_req), .mem_addr(mem_addr), .st(q.st), .ph(q.ph)
);

// File: tb/pt_xlate_unit_test.sv
module pt_xlate_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pt_base = 7'h00;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [5:0] req_vaddr = '0;
    logic [1:0] req_kind = '0;
    logic       req_user = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [1:0] rsp_trap;
    logic [7:0] rsp_rdata;
    logic       mem_req, mem_we;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;

    logic [7:0] mem [128];
    logic [6:0] rd_log [8];
    int rd_n = 0, wr_n = 0;
    int checks = 0, fails = 0, cycles = 0;

    // results of the last request
    logic [1:0] got_trap;
    logic [7:0] got_data;
    int got_rd, got_wr;
    logic [6:0] got_a0, got_a1;

    always #10 clk = ~clk;

    pt_xlate_unit uut (
        .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_n <= wr_n + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                rd_log[rd_n % 8] <= mem_addr;
                rd_n <= rd_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic set_pte(input int vpn, input logic [7:0] fl, input logic [7:0] fr);
        mem[7'(pt_base + 2*vpn)]     = fl;
        mem[7'(pt_base + 2*vpn + 1)] = fr;
    endtask

    task automatic do_req(input logic [5:0] va, input logic [1:0] kind,
                          input logic user, input logic [7:0] wd);
        int r0, w0;
        bit seen = 0;
        @(negedge clk);
        r0 = rd_n; w0 = wr_n;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        req_user = user; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (rsp_valid) begin
                seen = 1;
                got_trap = rsp_trap;
                got_data = rsp_rdata;
            end else @(negedge clk);
        end
        chk(seen, "R1", "response seen", seen, 1);
        @(negedge clk);
        chk(req_ready, "R1", "ready after response", req_ready, 1);
        got_rd = rd_n - r0; got_wr = wr_n - w0;
        got_a0 = rd_log[r0 % 8]; got_a1 = rd_log[(r0 + 1) % 8];
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0 && mem_req == 1'b0, "R8", "quiet after reset",
            {rsp_valid, mem_req}, 0);
    endtask

    task automatic t_example_load;
        set_pte(1, 8'hFC, 8'h07);
        do_req(6'd21, 2'b00, 1'b1, 8'h00);
        chk(got_trap == 2'b00, "R10", "load trap", got_trap, 0);
        chk(got_data == init_byte(8'h75), "R3", "load data from 0x75", got_data, init_byte(8'h75));
        chk(got_a0 == 7'h02 && got_a1 == 7'h03, "R2", "entry addresses",
            {got_a0, got_a1}, {7'h02, 7'h03});
        chk(got_rd == 3 && got_wr == 1, "R9", "reads/writes first load",
            got_rd * 16 + got_wr, 3 * 16 + 1);
        chk(mem[2] == 8'hFE, "R9", "accessed bit set", mem[2], 8'hFE);
    endtask

    task automatic t_repeat_load;
        do_req(6'd21, 2'b00, 1'b1, 8'h00);
        chk(got_wr == 0 && got_rd == 3, "R9", "no writeback when unchanged",
            got_rd * 16 + got_wr, 3 * 16);
        chk(mem[2] == 8'hFE, "R9", "flags unchanged", mem[2], 8'hFE);
    endtask

    task automatic t_store;
        do_req(6'h17, 2'b01, 1'b1, 8'hC3);
        chk(got_trap == 2'b00 && got_data == 8'h00, "R10", "store response",
            {got_trap, got_data}, 0);
        chk(mem[7'h77] == 8'hC3, "R10", "store data at 0x77", mem[7'h77], 8'hC3);
        chk(mem[2] == 8'hFF, "R9", "dirty bit set", mem[2], 8'hFF);
        chk(got_rd == 2 && got_wr == 2, "R9", "store writes", got_rd * 16 + got_wr, 2 * 16 + 2);
    endtask

    task automatic t_invalid;
        set_pte(2, 8'h7C, 8'h05);
        do_req(6'h20, 2'b00, 1'b0, 8'h00);
        chk(got_trap == 2'b01, "R4", "invalid trap (R7 priority)", got_trap, 1);
        chk(got_rd == 2 && got_wr == 0, "R8", "invalid no access", got_rd * 16 + got_wr, 2 * 16);
        chk(mem[4] == 8'h7C, "R8", "invalid entry untouched", mem[4], 8'h7C);
    endtask

    task automatic t_absent;
        set_pte(3, 8'h80, 8'h04);
        do_req(6'h31, 2'b01, 1'b1, 8'h11);
        chk(got_trap == 2'b10, "R5", "not present trap (R7 priority)", got_trap, 2);
        chk(got_wr == 0 && mem[7'h41] == init_byte(8'h41), "R8", "absent no write",
            got_wr, 0);
    endtask

    task automatic t_protection;
        set_pte(0, 8'hE0, 8'h06);
        do_req(6'h03, 2'b00, 1'b1, 8'h00);
        chk(got_trap == 2'b11, "R6", "user without U", got_trap, 3);
        chk(mem[0] == 8'hE0, "R8", "prot fault no writeback", mem[0], 8'hE0);
        do_req(6'h03, 2'b00, 1'b0, 8'h00);
        chk(got_trap == 2'b00 && got_data == init_byte(8'h63), "R6", "supervisor load ok",
            got_data, init_byte(8'h63));
        do_req(6'h04, 2'b01, 1'b0, 8'h99);
        chk(got_trap == 2'b11, "R6", "store without W", got_trap, 3);
        chk(mem[7'h64] == init_byte(8'h64), "R8", "refused store left memory",
            mem[7'h64], init_byte(8'h64));
        do_req(6'h05, 2'b10, 1'b0, 8'h00);
        chk(got_trap == 2'b11, "R6", "fetch without X", got_trap, 3);
    endtask

    task automatic t_fetch;
        set_pte(0, 8'hCC, 8'h06);
        do_req(6'h0A, 2'b10, 1'b1, 8'h00);
        chk(got_trap == 2'b00 && got_data == init_byte(8'h6A), "R10", "user fetch",
            got_data, init_byte(8'h6A));
        chk(mem[0] == 8'hCE, "R9", "fetch sets accessed only", mem[0], 8'hCE);
    endtask

    task automatic t_base;
        pt_base = 7'h40;
        set_pte(2, 8'hF0, 8'h05);
        do_req(6'h2F, 2'b00, 1'b0, 8'h00);
        chk(got_a0 == 7'h44 && got_a1 == 7'h45, "R2", "entry addresses at base 0x40",
            {got_a0, got_a1}, {7'h44, 7'h45});
        chk(got_data == init_byte(8'h5F), "R3", "load via moved table",
            got_data, init_byte(8'h5F));
    endtask

    initial begin
        for (int a = 0; a < 128; a++) mem[a] = init_byte(a);
        for (int a = 0; a < 8; a++) rd_log[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_example_load;
        t_repeat_load;
        t_store;
        t_invalid;
        t_absent;
        t_protection;
        t_fetch;
        t_base;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule